// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor

This block adds or subtracts two unsigned operands one bit per clock. Each operand sits in its own right-shift register that is loaded in parallel in a single cycle. After the registers are loaded, a start request runs one full adder over the bit pairs, least significant bit first. A carry flip-flop links each step to the next. Each sum bit enters the top of the first operand register as that register shifts right, so after the last step the first operand register holds the result and drives the result port.

For subtraction, the second operand bit is inverted before it reaches the adder and the carry flip-flop starts at 1. The block therefore computes A + ~B + 1, and the final carry reads 1 when no borrow occurred. For addition the carry starts at 0. The second operand register rotates during the operation by default, so it holds its loaded value again at the end. A new start without a new load therefore works on the previous result and the same second operand.

Top module: `serial_addsub`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `carry_out` and `result` are all 0.
- R2: A `load` pulse while `busy` is low copies `a_in` into the first operand register and `b_in` into the second in one clock. `result` shows `a_in` in the following cycle.
- R3: A `start` pulse while idle makes `busy` high for exactly WIDTH cycles, beginning the cycle after `start`. `done` is then a single-cycle pulse in the first cycle after `busy` falls.
- R4: With `sub`=0 at start, `result` equals (A + B) mod 2^WIDTH when `done` is high, and `carry_out` equals the carry out of the top bit.
- R5: With `sub`=1 at start, `result` equals (A - B) mod 2^WIDTH when `done` is high, and `carry_out` is 1 exactly when A >= B as unsigned numbers.
- R6: `load` is ignored while `busy` is high. The operation's result is the same as without the load.
- R7: `start` is ignored while `busy` is high. It neither extends nor restarts the operation and causes no second `done`.
- R8: A `start` without a prior `load` operates on the current registers: the first operand is the previous result and the second is the previously loaded operand.
- R9: When `load` and `start` are high in the same idle cycle, the load takes effect and the start is ignored, so `busy` stays low.
- R10: While idle with no `load`, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load request |
| start | input | 1 | Start a serial operation |
| sub | input | 1 | 1 selects subtraction, sampled with start |
| a_in | input | WIDTH | Parallel value for the first operand |
| b_in | input | WIDTH | Parallel value for the second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Contents of the first operand register |
| carry_out | output | 1 | Carry flip-flop; final carry when done is high |

## Verification
A wrong internal state shows at the ports within one operation, at most WIDTH+1 cycles after start. A miscounting bit counter changes the length of `busy` and misplaces `done`. A bad carry initial value or a missing inversion of the second operand corrupts bit 0 of `result` and usually `carry_out`. A shift register that rotates when it should not, or fails to, makes the next chained operation disagree with the expected sum. The bench compares every operand pair in both modes against arithmetic computed from the requirements, then runs chained and overlapping requests.

// File: rtl/serial_addsub_pkg.sv
package serial_addsub_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  function automatic int cnt_bits(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/sas_shreg.sv
module sas_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q,
  output logic             lsb
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_en)  q <= par_in;
    else if (shift_en) q <= {ser_in, q[WIDTH-1:1]};
  end

  assign lsb = q[0];

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> $stable(q));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(par_in)));
endmodule

// File: rtl/sas_bitslice.sv
module sas_bitslice (
  input  logic clk,
  input  logic rst,
  input  logic init_en,
  input  logic init_val,
  input  logic step_en,
  input  logic invert_b,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum,
  output logic carry_q
);
  logic b_eff;
  logic cout;

  always_comb begin
    b_eff = b_bit ^ invert_b;
    sum   = a_bit ^ b_eff ^ carry_q;
    cout  = (a_bit & b_eff) | (carry_q & (a_bit ^ b_eff));
  end

  always_ff @(posedge clk) begin
    if (rst)          carry_q <= 1'b0;
    else if (init_en) carry_q <= init_val;
    else if (step_en) carry_q <= cout;
  end

  assert_carry_init_R5: assert property (@(posedge clk) disable iff (rst)
    init_en |=> (carry_q == $past(init_val)));
endmodule

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import serial_addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_req,
  input  logic start_req,
  input  logic sub_req,
  output logic load_en,
  output logic shift_en,
  output logic init_en,
  output logic sub_mode,
  output logic busy,
  output logic done
);
  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          sub_q;

  always_comb begin
    load_en  = load_req && (phase_q == PH_IDLE);
    init_en  = start_req && !load_req && (phase_q == PH_IDLE);
    shift_en = (phase_q == PH_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sub_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (init_en) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
        sub_q   <= sub_req;
      end else if (phase_q == PH_RUN) begin
        if (cnt_q == LAST) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy     = (phase_q == PH_RUN);
  assign done     = done_q;
  assign sub_mode = sub_q;

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt_q == '0));
  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && load_req) |=> !busy);
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int WIDTH    = 4,
  parameter bit B_ROTATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             start,
  input  logic             sub,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic load_en, shift_en, init_en, sub_mode;
  logic a_lsb, b_lsb, b_fill, sum_bit, carry_q;
  logic [WIDTH-1:0] a_q, b_q;

  sas_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .load_req(load), .start_req(start), .sub_req(sub),
    .load_en(load_en), .shift_en(shift_en), .init_en(init_en),
    .sub_mode(sub_mode), .busy(busy), .done(done)
  );

  sas_shreg #(.WIDTH(WIDTH)) u_areg (
    .clk(clk), .rst(rst), .load_en(load_en), .shift_en(shift_en),
    .par_in(a_in), .ser_in(sum_bit), .q(a_q), .lsb(a_lsb)
  );

  generate
    if (B_ROTATE) begin : g_brot
      assign b_fill = b_lsb;
    end else begin : g_bzero
      assign b_fill = 1'b0;
    end
  endgenerate

  sas_shreg #(.WIDTH(WIDTH)) u_breg (
    .clk(clk), .rst(rst), .load_en(load_en), .shift_en(shift_en),
    .par_in(b_in), .ser_in(b_fill), .q(b_q), .lsb(b_lsb)
  );

  sas_bitslice u_slice (
    .clk(clk), .rst(rst), .init_en(init_en), .init_val(sub),
    .step_en(shift_en), .invert_b(sub_mode), .a_bit(a_lsb), .b_bit(b_lsb),
    .sum(sum_bit), .carry_q(carry_q)
  );

  assign result    = a_q;
  assign carry_out = carry_q;

  if (B_ROTATE) begin : g_chk_rot
    assert_b_restored_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (b_q == $past(b_q, WIDTH + 1)));
  end

  assert_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && load) |=> (busy || done));
endmodule

// File: tb/tb_serial_addsub.sv
module tb_serial_addsub;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, start = 1'b0, sub = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic busy, done, carry_out;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int dones_seen = 0;
  logic [W:0] expq [$];
  int a_m, b_m;

  always #10 clk = ~clk;

  serial_addsub #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .load(load), .start(start), .sub(sub),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
    .result(result), .carry_out(carry_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected {carry,result} on every done pulse (R4, R5, R7)
  always @(negedge clk) begin
    if (!rst && done) begin
      dones_seen++;
      if (expq.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        logic [W:0] e;
        e = expq.pop_front();
        chk("R4/R5 result", int'(result), int'(e[W-1:0]));
        chk("R4/R5 carry_out", int'(carry_out), int'(e[W]));
      end
    end
  end

  task automatic do_load(input int a, input int b);
    @(negedge clk);
    load = 1'b1; a_in = W'(a); b_in = W'(b);
    @(negedge clk);
    load = 1'b0;
    a_m = a; b_m = b;
    chk("R2 load result", int'(result), a);
  endtask

  // mode: 0 plain, 1 load during busy (R6), 2 start during busy (R7)
  task automatic do_op(input bit s, input int mode);
    int exp_r, exp_c, nb;
    if (s) begin
      exp_r = (a_m - b_m) & MASK;
      exp_c = (a_m >= b_m) ? 1 : 0;
    end else begin
      exp_r = (a_m + b_m) & MASK;
      exp_c = ((a_m + b_m) >> W) & 1;
    end
    expq.push_back({1'(exp_c), W'(exp_r)});
    @(negedge clk);
    start = 1'b1; sub = s;
    @(negedge clk);
    start = 1'b0; sub = 1'b0;
    nb = 0;
    while (busy && nb < 20) begin
      nb++;
      if (nb == 2 && mode == 1) begin load = 1'b1; a_in = ~W'(a_m); b_in = W'(5); end
      else if (nb == 2 && mode == 2) begin start = 1'b1; sub = ~s; end
      else begin load = 1'b0; start = 1'b0; sub = 1'b0; end
      @(negedge clk);
    end
    load = 1'b0; start = 1'b0; sub = 1'b0;
    chk("R3 busy length", nb, W);
    chk("R3 done after busy", int'(done), 1);
    a_m = exp_r;
    if (mode != 0) begin
      @(negedge clk);
      chk(mode == 1 ? "R6 result after ignored load" : "R7 no restart",
          int'(busy) * 100 + int'(result), exp_r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 carry_out", int'(carry_out), 0);
    rst = 1'b0;

    // exhaustive add and subtract (R4, R5)
    for (int a = 0; a <= MASK; a++)
      for (int b = 0; b <= MASK; b++) begin
        do_load(a, b); do_op(1'b0, 0);
        do_load(a, b); do_op(1'b1, 0);
      end

    // R8: chained start without load
    do_load(3, 5);
    do_op(1'b0, 0);
    do_op(1'b0, 0);
    do_op(1'b1, 0);
    chk("R8 chained result", int'(result), 8);

    // R6 and R7
    do_load(9, 4); do_op(1'b0, 1);
    do_load(2, 7); do_op(1'b1, 2);

    // R9: load and start together
    @(negedge clk);
    load = 1'b1; start = 1'b1; a_in = W'(6); b_in = W'(1);
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    chk("R9 busy stays low", int'(busy), 0);
    chk("R9 load taken", int'(result), 6);
    a_m = 6; b_m = 1;

    // R10: hold while idle
    repeat (5) @(negedge clk);
    chk("R10 result held", int'(result), 6);
    do_op(1'b1, 0);

    repeat (3) @(negedge clk);
    chk("R7 queue drained", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule